// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Byte Memory Write Engine

This block is a clocked model of the control side of a 2048 x 8 byte-wide nonvolatile memory. The host drives three active-low strobes (select, read gate, write gate), an 11-bit address and an 8-bit data bus. These inputs are sampled on the system clock. Read cycles return array contents through a registered output with a separate drive-enable flag. Write strobes load bytes into a sixteen-entry page buffer. Each accepted strobe reopens a byte-load window. When that window lapses, a self-timed programming phase copies the loaded entries into the array.

During programming the block ignores write strobes. Reads during programming return the last loaded byte with its top bit inverted, so software can test that bit to see when programming has finished. A minimum strobe width filters out glitches. After reset, writes stay disarmed until the write condition has been seen false once, so a strobe held through power-up cannot write.

The byte-load window, the programming time and the glitch filter length are parameters counted in clock cycles.

Top module: `eep_page_engine`

## Requirements
- R1: With select low, read gate low and write gate high at a clock edge, the next cycle shows `dout_en`=1 and `dout` equal to the array byte at the sampled address (outside programming).
- R2: In any cycle that follows an edge without the read condition, `dout_en` is 0 and `dout` is 0.
- R3: The write condition is select low, write gate low and read gate high. A strobe is accepted on its GLITCH_CYC-th consecutive sampled cycle. The address is taken at that edge. The stored data is `din` from the last edge at which the condition still held.
- R4: A strobe lasting fewer than GLITCH_CYC consecutive cycles writes nothing.
- R5: Every accepted strobe restarts the byte-load window. Programming begins once WIN_CYC-1 load-phase edges have elapsed since the last acceptance and no accepted strobe is still held.
- R6: The page is address bits 10..4 and the offset is bits 3..0. While loading, a strobe to a page other than the open one is ignored and does not restart the window.
- R7: Programming lasts PROG_CYC cycles and cannot be cut short. Strobes during programming are ignored. Loaded offsets receive their buffered bytes, and offsets that were not loaded keep their old array contents.
- R8: During programming, a read at any address returns the last loaded byte with bit 7 complemented. Once programming ends, reads return true data.
- R9: After reset, no strobe is accepted until the write condition has been sampled false at least once.
- R10: During reset, `dout_en` and `dout` are 0.
- R11: With the read gate low, a low select and write gate form no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low read gate |
| we_n | input | 1 | Active-low write gate |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data, 0 when not driving |
| dout_en | output | 1 | Read data valid, stands in for the output driver enable |

## Verification
The assertions assume that the strobes and the address are synchronous to the clock. They also assume the address stays constant for the whole of an accepted write strobe, and that a held strobe never spans the start of programming. The stimulus meets these assumptions as follows. It changes inputs only on falling clock edges. It holds each write strobe with a fixed address and returns it to idle before starting the next strobe. It places reads only between strobes, never during one.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eep_state_e;
endpackage

// File: rtl/eep_wr_filter.sv
// Qualifies the combined write condition: it must persist GLITCH_CYC cycles
// and must have been seen inactive since reset before a strobe is accepted.
module eep_wr_filter #(
    parameter int GLITCH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act_i,
    output logic acc_o
);
    localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC + 1) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d   = f_q;
        acc_o = 1'b0;
        if (!wr_act_i) begin
            f_d.cnt   = '0;
            f_d.armed = 1'b1;
        end else begin
            if (f_q.cnt != CW'(GLITCH_CYC))
                f_d.cnt = f_q.cnt + 1'b1;
            acc_o = f_q.armed && (f_q.cnt == CW'(GLITCH_CYC - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // R4
    acc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |=> !acc_o);

    generate
        if (GLITCH_CYC > 1) begin : g_width
            // R4
            acc_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
                acc_o |-> $past(wr_act_i));
        end
    endgenerate
endmodule

// File: rtl/eep_tick_counter.sv
// Saturating cycle counter with synchronous clear.
module eep_tick_counter #(
    parameter int LIMIT = 16,
    localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (en_i && (cnt_q != CW'(LIMIT - 1)))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CW'(LIMIT - 1);
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/eep_array.sv
// Byte array: one synchronous write port, one asynchronous read port.
module eep_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_page_engine.sv
module eep_page_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_W     = 4,
    parameter int GLITCH_CYC = 2,
    parameter int WIN_CYC    = 1000,
    parameter int PROG_CYC   = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PAGE_AW    = ADDR_W - PAGE_W;
    localparam int WCW        = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int PCW        = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;

    typedef struct packed {
        eep_state_e          st;
        logic                stb;
        logic [PAGE_W-1:0]   off;
        logic [PAGE_AW-1:0]  page;
        logic [DATA_W-1:0]   wdat;
        logic [DATA_W-1:0]   last;
        logic [PAGE_BYTES-1:0] vld;
        logic                oen;
        logic [DATA_W-1:0]   dout;
    } ctl_t;

    ctl_t              c_d, c_q;
    logic [DATA_W-1:0] bufd_d [PAGE_BYTES];
    logic [DATA_W-1:0] bufd_q [PAGE_BYTES];

    logic              wr_act, rd_act, acc, take, expire, busy;
    logic              win_last, prog_last, slot_ok;
    logic [WCW-1:0]    wcnt;
    logic [PCW-1:0]    pcnt;
    logic [PAGE_W-1:0] slot;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    assign wr_act = !ce_n && !we_n && oe_n;
    assign rd_act = !ce_n && !oe_n && we_n;
    assign busy   = (c_q.st == ST_PROG);

    eep_wr_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_act_i(wr_act),
        .acc_o   (acc)
    );

    eep_tick_counter #(.LIMIT(WIN_CYC)) u_win_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(take),
        .en_i (c_q.st == ST_LOAD),
        .cnt_o(wcnt)
    );

    eep_tick_counter #(.LIMIT(PROG_CYC)) u_prog_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(expire),
        .en_i (busy),
        .cnt_o(pcnt)
    );

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .we_i   (mem_we),
        .waddr_i(mem_waddr),
        .wdata_i(mem_wdata),
        .raddr_i(addr),
        .rdata_o(mem_rdata)
    );

    assign win_last  = (wcnt == WCW'(WIN_CYC - 1));
    assign prog_last = (pcnt == PCW'(PROG_CYC - 1));
    assign slot      = pcnt[PAGE_W-1:0];
    assign slot_ok   = ({1'b0, pcnt} < (PCW + 1)'(PAGE_BYTES));

    always_comb begin
        c_d       = c_q;
        bufd_d    = bufd_q;
        mem_we    = 1'b0;
        mem_waddr = {c_q.page, slot};
        mem_wdata = bufd_q[slot];

        take = acc && !busy &&
               ((c_q.st == ST_IDLE) || (addr[ADDR_W-1:PAGE_W] == c_q.page));
        expire = (c_q.st == ST_LOAD) && !c_q.stb && win_last && !take;

        // strobe capture and release into the page buffer
        if (take) begin
            c_d.stb  = 1'b1;
            c_d.off  = addr[PAGE_W-1:0];
            c_d.page = addr[ADDR_W-1:PAGE_W];
            c_d.wdat = din;
            c_d.st   = ST_LOAD;
        end else if (c_q.stb) begin
            if (wr_act) begin
                c_d.wdat = din;
            end else begin
                c_d.stb             = 1'b0;
                bufd_d[c_q.off]     = c_q.wdat;
                c_d.vld[c_q.off]    = 1'b1;
                c_d.last            = c_q.wdat;
            end
        end

        if (expire)
            c_d.st = ST_PROG;

        // programming: commit one loaded slot per cycle, then finish
        if (busy) begin
            if (slot_ok && c_q.vld[slot])
                mem_we = 1'b1;
            if (prog_last) begin
                c_d.st  = ST_IDLE;
                c_d.vld = '0;
            end
        end

        // registered read path
        c_d.oen = rd_act;
        if (!rd_act)
            c_d.dout = '0;
        else if (busy)
            c_d.dout = {~c_q.last[DATA_W-1], c_q.last[DATA_W-2:0]};
        else
            c_d.dout = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) bufd_q[i] <= '0;
        end else begin
            c_q <= c_d;
            for (int i = 0; i < PAGE_BYTES; i++) bufd_q[i] <= bufd_d[i];
        end
    end

    assign dout    = c_q.dout;
    assign dout_en = c_q.oen;

    // R2
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_act) |-> (!dout_en && (dout == '0)));

    // R6
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_LOAD) && ($past(c_q.st) == ST_LOAD)) |-> $stable(c_q.page));

    // R5
    prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (($past(c_q.st) == ST_LOAD) && !$past(c_q.stb) && $past(win_last)));

    // R7
    prog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy) |-> $past(prog_last));

    // R8
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(busy)) |-> (dout[DATA_W-1] != c_q.last[DATA_W-1]));
endmodule

// File: tb/eep_page_engine_tb.sv
module eep_page_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int G = 3;
    localparam int W = 40;
    localparam int P = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R10";

    always #(CLK_PERIOD / 2) clk = ~clk;

    eep_page_engine #(
        .ADDR_W(11), .DATA_W(8), .PAGE_W(4),
        .GLITCH_CYC(G), .WIN_CYC(W), .PROG_CYC(P)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_mem [0:2047];
    bit         m_known [0:2047];
    logic [7:0] m_buf [0:15];
    bit         m_bv [0:15];
    int m_fcnt, m_armed, m_st, m_stb, m_off, m_page, m_wt, m_pt;
    logic [7:0] m_dat, m_last;
    logic [7:0] e_dout = '0;
    bit e_en = 0, e_known = 1, started = 0;

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_fcnt = 0; m_armed = 0; m_st = 0; m_stb = 0; m_off = 0;
            m_page = 0; m_wt = W - 1; m_pt = P - 1; m_dat = 0; m_last = 0;
            for (int i = 0; i < 16; i++) begin m_bv[i] = 0; m_buf[i] = 0; end
            e_en = 0; e_dout = 0; e_known = 1;
        end else begin
            bit wa, ra, acc, tk, exp_w, bz;
            int nst;
            wa = !ce_n && !we_n && oe_n;
            ra = !ce_n && !oe_n && we_n;
            acc = wa && (m_armed != 0) && (m_fcnt == G - 1);
            if (wa) m_fcnt = (m_fcnt < G) ? m_fcnt + 1 : G;
            else begin m_fcnt = 0; m_armed = 1; end
            bz = (m_st == 2);
            e_en = ra;
            if (!ra) begin e_dout = 0; e_known = 1; end
            else if (bz) begin e_dout = m_last ^ 8'h80; e_known = 1; end
            else begin e_dout = m_mem[addr]; e_known = m_known[addr]; end
            tk = acc && !bz && (m_st == 0 || (int'(addr) / 16) == m_page);
            exp_w = (m_st == 1) && (m_stb == 0) && (m_wt == W - 1) && !tk;
            nst = m_st;
            if (bz) begin
                if (m_pt < 16 && m_bv[m_pt]) begin
                    m_mem[m_page * 16 + m_pt] = m_buf[m_pt];
                    m_known[m_page * 16 + m_pt] = 1;
                end
                if (m_pt == P - 1) begin
                    nst = 0;
                    for (int i = 0; i < 16; i++) m_bv[i] = 0;
                end else m_pt++;
            end
            if (m_st == 1 && m_wt < W - 1) m_wt++;
            if (exp_w) begin nst = 2; m_pt = 0; end
            if (tk) begin
                m_stb = 1; m_off = int'(addr) % 16; m_page = int'(addr) / 16;
                m_dat = din; m_wt = 0; nst = 1;
            end else if (m_stb != 0) begin
                if (wa) m_dat = din;
                else begin
                    m_stb = 0; m_buf[m_off] = m_dat; m_bv[m_off] = 1; m_last = m_dat;
                end
            end
            m_st = nst;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the reference
    always @(negedge clk) begin
        if (started && !done) begin
            chk({cur_req, " dout_en"}, {7'd0, dout_en}, {7'd0, e_en});
            if (e_known) chk({cur_req, " dout"}, dout, e_dout);
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog all-R actual=%0d expected=<100000", cyc);
            summary();
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
        end
    endtask

    task automatic strobe(input logic [10:0] a, input logic [7:0] d, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ce_n = 0; oe_n = 1; we_n = 0; addr = a;
            din = (i == len - 1) ? d : ~d;
        end
        @(negedge clk); ce_n = 1; we_n = 1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input logic [10:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(negedge clk);
        chk({tag, " read enable"}, {7'd0, dout_en}, 8'd1);
        chk({tag, " read data"}, dout, exp);
        ce_n = 1; oe_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10";
        chk("R10 reset dout_en", {7'd0, dout_en}, 8'd0);
        chk("R10 reset dout", dout, 8'd0);
        @(negedge clk); rst_n = 1;
        idle(3);

        // R3 / R5: two full pages, data taken from the last strobe cycle
        cur_req = "R3";
        for (int i = 0; i < 16; i++) strobe(11'h000 + 11'(i), 8'h10 + 8'(i), 4);
        idle(W + P + 5);
        for (int i = 0; i < 16; i++) strobe(11'h120 + 11'(i), 8'hA0 + 8'(i), 4);
        idle(W + 5);
        cur_req = "R8";
        rd_chk(11'h7FF, 8'h2F, "R8 poll any address");
        rd_chk(11'h12F, 8'h2F, "R8 poll last byte");
        idle(P);
        rd_chk(11'h12F, 8'hAF, "R8 true data after");
        cur_req = "R1";
        rd_chk(11'h003, 8'h13, "R1 read page0");
        rd_chk(11'h127, 8'hA7, "R1 read page12");

        // R5: window restarted by each strobe
        cur_req = "R5";
        strobe(11'h120, 8'h31, 4);
        idle(28);
        rd_chk(11'h12F, 8'hAF, "R5 still loading");
        strobe(11'h121, 8'h32, 4);
        idle(28);
        rd_chk(11'h12E, 8'hAE, "R5 still loading 2");
        idle(15);
        rd_chk(11'h000, 8'hB2, "R5 programming started");
        idle(P);
        cur_req = "R7";
        rd_chk(11'h120, 8'h31, "R7 loaded slot 0");
        rd_chk(11'h121, 8'h32, "R7 loaded slot 1");
        rd_chk(11'h122, 8'hA2, "R7 unloaded slot kept");

        // R6: other-page strobe ignored
        cur_req = "R6";
        strobe(11'h125, 8'h45, 4);
        strobe(11'h005, 8'h99, 4);
        strobe(11'h12A, 8'h4A, 4);
        idle(W + P + 10);
        rd_chk(11'h005, 8'h15, "R6 other page untouched");
        rd_chk(11'h125, 8'h45, "R6 same page byte");
        rd_chk(11'h12A, 8'h4A, "R6 same page byte 2");

        // R4: short strobe
        cur_req = "R4";
        strobe(11'h003, 8'hEE, G - 1);
        idle(W + P);
        rd_chk(11'h003, 8'h13, "R4 glitch ignored");

        // R11: read gate low blocks writes
        cur_req = "R11";
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 11'h004; din = 8'hEE;
        end
        idle(W + P);
        rd_chk(11'h004, 8'h14, "R11 no write with read gate low");

        // R7: strobe during programming ignored
        cur_req = "R7";
        strobe(11'h12B, 8'h5B, 4);
        idle(W + 5);
        strobe(11'h12C, 8'h66, 4);
        idle(P);
        rd_chk(11'h12B, 8'h5B, "R7 byte committed");
        rd_chk(11'h12C, 8'hAC, "R7 busy strobe ignored");

        // R9: strobe held through reset is not accepted
        cur_req = "R9";
        @(negedge clk); rst_n = 0;
        ce_n = 0; oe_n = 1; we_n = 0; addr = 11'h000; din = 8'h55;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (10) @(negedge clk);
        idle(W + P + 10);
        rd_chk(11'h000, 8'h10, "R9 power-up strobe ignored");

        idle(3);
        summary();
    end
endmodule